// File: doc/BRIEF.md
# Event Toggle-List Scheduler

This block turns a bank of twelve tone dividers into a compact stream of change events. It does not tick every divider once per reference period. Each channel keeps three values: the count left until its next edge, the length of its current half period, and a small signed step. On every pass the scheduler subtracts the interval that has just elapsed from all channels, one channel per clock. It gathers the channels that reach zero into a toggle mask, reloads them, and keeps a running minimum of the new remaining counts.

Each pass ends by writing one 32-bit entry into a ring of 64 entries that lives outside the block. An entry holds the toggle mask from the previous pass and a delay code for the gap to the next event. The mask arrives one entry late on purpose: a replaying consumer first waits out the delay and only then applies the mask. The consumer returns its read pointer, and the scheduler stops writing while the ring is full.

A channel with an even reference divisor has a step of zero and keeps one half-period length. A channel with an odd divisor alternates between two lengths that differ by one. Its waveform therefore has the right average period on an integer time grid.

Top module: `tog_sched`

## Requirements
- R1: After reset, `wr_ptr` is 0 and `wr_en` stays low until the first pass over all channels completes. The first entry has an all-zero mask and delay code 118, because the initial interval is the smallest half period, 119.
- R2: Entry layout. Bits [7:0] hold mask bits for channels 7..0. Bits [11:8] hold mask bits for channels 11..8. Bits [15:12] are zero. Bits [23:16] hold the delay code. Bits [31:24] are zero.
- R3: The delay code equals (E_next - E_now) - 1. E_now is the event time whose mask the entry carries, and E_next is the earliest later event over all channels. The minimum search starts from 255.
- R4: The mask in entry k names exactly the channels that toggle at event time E_k, with E_0 = 0 and an empty mask for entry 0. The mask is therefore written one entry after the pass that detected it.
- R5: A channel with an odd divisor has initial length L and step +1. It toggles after intervals L, L, L+1, L, L+1, and so on: each expiry reloads the count from the current length, then adds the step to the length, then negates the step.
- R6: A channel with an even divisor toggles at a fixed interval equal to its initial length.
- R7: Pointers carry one wrap bit above the 6-bit index. No entry is written while the index bits of `wr_ptr` and `rd_ptr` match and their wrap bits differ. Writing resumes within one pass after `rd_ptr` advances, and no entry is lost or repeated.
- R8: `wr_ptr` rises by exactly one for each write and wraps modulo 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_ptr | input | 7 | Consumer read pointer: wrap bit and 6-bit index |
| wr_en | output | 1 | Write strobe for the ring; one entry per high cycle |
| wr_ptr | output | 7 | Write pointer: wrap bit and 6-bit index of the slot written when `wr_en` is high |
| wr_entry | output | 32 | Entry to store: mask, delay code and pad |

## Verification
A wrong remaining count, length or step in one channel shifts that channel's later toggles. The first entry that carries the shifted event then shows a wrong mask, and its neighbours show a wrong delay code, within a few hundred reference units of the fault. A broken minimum search corrupts the very next delay code. A lost one-entry mask delay makes every non-empty mask appear one entry early. A pointer or full-detection fault appears as a write into a full ring, a missing write after the reader frees a slot, or a `wr_ptr` that differs from the number of writes seen.

// File: rtl/tog_sched_pkg.sv
// Package: shared types for the event toggle-list scheduler.
// Assumes: nothing beyond standard SystemVerilog.
package tog_sched_pkg;

    // Two-phase sequencer: serial scan over channels, then one emit slot.
    typedef enum logic [0:0] {
        ST_SCAN = 1'b0,
        ST_EMIT = 1'b1
    } sched_state_e;

    // Width of the zero pad byte that closes every entry.
    localparam int PAD_W  = 8;
    // Width of the mask field (two bytes, unused bits held at zero).
    localparam int MASK_W = 16;

endpackage

// File: rtl/tog_sched_chan.sv
// Module: one tone channel of the scheduler.
// Holds the remaining count, the current half-period length and the
// signed step. When selected, it subtracts the elapsed interval and, on
// reaching zero, reloads and advances its length.
// Assumes: min_val never exceeds the remaining count when sel is high.
module tog_sched_chan #(
    parameter int            CW        = 8,
    parameter logic [CW-1:0] INIT_LEN  = 8'd119,
    parameter bit            ODD_DIV   = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic [CW-1:0] min_val,
    output logic          hit,
    output logic [CW-1:0] cand
);

    logic [CW-1:0]     cnt_q;
    logic [CW-1:0]     len_q;
    logic signed [1:0] step_q;
    logic [CW-1:0]     diff;
    logic              zero;

    // Remaining count after the elapsed interval, and the value it will hold.
    always_comb begin
        diff = cnt_q - min_val;
        zero = (diff == '0);
        hit  = sel && zero;
        cand = zero ? len_q : diff;
    end

    // Per-channel state update on the cycle this channel is scanned.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= INIT_LEN;
            len_q  <= INIT_LEN;
            step_q <= ODD_DIV ? 2'sd1 : 2'sd0;
        end else if (sel) begin
            if (zero) begin
                cnt_q  <= len_q;
                len_q  <= len_q + {{(CW-2){step_q[1]}}, step_q};
                step_q <= -step_q;
            end else begin
                cnt_q  <= diff;
            end
        end
    end

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        sel |-> (cnt_q >= min_val)); // R3

    AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (len_q == INIT_LEN) || (ODD_DIV && (len_q == CW'(INIT_LEN + 1'b1)))); // R5

    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (cnt_q == $past(len_q))); // R5

endmodule

// File: rtl/tog_sched_wptr.sv
// Module: ring write pointer with a wrap bit and full detection.
// Full means equal index bits with different wrap bits.
// Assumes: the consumer never moves rd_ptr past wr_ptr.
module tog_sched_wptr #(
    parameter int PW = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        adv,
    input  logic [PW:0] rd_ptr,
    output logic [PW:0] wr_ptr,
    output logic        full
);

    localparam logic [PW:0] DEPTH_V = (PW+1)'(1 << PW);

    logic [PW:0] occ;

    // Ring is full when the writer is exactly one lap ahead.
    always_comb begin
        full = (wr_ptr[PW-1:0] == rd_ptr[PW-1:0]) && (wr_ptr[PW] != rd_ptr[PW]);
        occ  = wr_ptr - rd_ptr;
    end

    // Advance by one slot per accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_ptr <= '0;
        else if (adv) wr_ptr <= wr_ptr + 1'b1;
    end

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (wr_ptr == $past(wr_ptr) + 1'b1)); // R8

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(wr_ptr)); // R8

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= DEPTH_V); // R7

endmodule

// File: rtl/tog_sched.sv
// Module: event toggle-list scheduler (top).
// Scans the channels serially from the highest index down to 0, one per
// clock. It collects the expired channels into a mask and tracks the
// minimum remaining count. Each pass then emits {previous mask, current
// interval - 1} into an external ring, holding while the ring is full.
// Assumes: CW = 8 for the 32-bit entry format, NCH <= 16, and every gap
// between events is at most 255.
module tog_sched
    import tog_sched_pkg::*;
#(
    parameter int                NCH      = 12,
    parameter int                CW       = 8,
    parameter int                PW       = 6,
    parameter logic [NCH*CW-1:0] LEN_INIT = {8'd225, 8'd213, 8'd201, 8'd189,
                                             8'd179, 8'd169, 8'd159, 8'd150,
                                             8'd142, 8'd134, 8'd126, 8'd119},
    parameter logic [NCH-1:0]    ODD_INIT = 12'b1001_0011_0011
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PW:0]           rd_ptr,
    output logic                  wr_en,
    output logic [PW:0]           wr_ptr,
    output logic [PAD_W+CW+MASK_W-1:0] wr_entry
);

    localparam int IW = $clog2(NCH);

    // Smallest initial length: the first interval of the schedule.
    function automatic logic [CW-1:0] min_len(input logic [NCH*CW-1:0] v);
        logic [CW-1:0] m;
        m = '1;
        for (int i = 0; i < NCH; i++)
            if (v[i*CW +: CW] < m) m = v[i*CW +: CW];
        return m;
    endfunction

    localparam logic [CW-1:0] INIT_MIN = min_len(LEN_INIT);

    sched_state_e   state_q;
    logic [IW-1:0]  idx_q;
    logic [CW-1:0]  min_q;
    logic [CW-1:0]  nmin_q;
    logic [NCH-1:0] tog_q;
    logic [NCH-1:0] ptog_q;
    logic [NCH-1:0] hit_v;
    logic [CW-1:0]  cand_v [NCH];
    logic [CW-1:0]  cand_sel;
    logic           full;
    logic           scan;

    assign scan = (state_q == ST_SCAN);

    // One channel instance per tone, each with its own initial length and step.
    for (genvar g = 0; g < NCH; g++) begin : g_chan
        tog_sched_chan #(
            .CW       (CW),
            .INIT_LEN (LEN_INIT[g*CW +: CW]),
            .ODD_DIV  (ODD_INIT[g])
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel     (scan && (idx_q == IW'(g))),
            .min_val (min_q),
            .hit     (hit_v[g]),
            .cand    (cand_v[g])
        );
    end

    // Pick the next remaining count of the channel under scan.
    always_comb begin
        cand_sel = '1;
        for (int i = 0; i < NCH; i++)
            if (idx_q == IW'(i)) cand_sel = cand_v[i];
    end

    tog_sched_wptr #(.PW(PW)) u_wptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (wr_en),
        .rd_ptr (rd_ptr),
        .wr_ptr (wr_ptr),
        .full   (full)
    );

    // Emit slot output: previous pass's mask with the current delay code.
    always_comb begin
        wr_en    = (state_q == ST_EMIT) && !full;
        wr_entry = {PAD_W'(0), min_q - 1'b1, MASK_W'(ptog_q)};
    end

    // Sequencer, mask accumulation and running minimum search.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SCAN;
            idx_q   <= IW'(NCH-1);
            min_q   <= INIT_MIN;
            nmin_q  <= '1;
            tog_q   <= '0;
            ptog_q  <= '0;
        end else if (scan) begin
            tog_q <= tog_q | hit_v;
            if (cand_sel < nmin_q) nmin_q <= cand_sel;
            if (idx_q == '0) state_q <= ST_EMIT;
            else             idx_q   <= idx_q - 1'b1;
        end else if (!full) begin
            min_q   <= nmin_q;
            ptog_q  <= tog_q;
            nmin_q  <= '1;
            tog_q   <= '0;
            idx_q   <= IW'(NCH-1);
            state_q <= ST_SCAN;
        end
    end

    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_entry[MASK_W +: CW] != '1)); // R3

    AST_MIN_POSITIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMIT) |-> (nmin_q != '0)); // R3

    AST_HOLD_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_EMIT) && full) |=> ((state_q == ST_EMIT) && $stable(ptog_q))); // R7

endmodule

// File: tb/tog_sched_bench.sv
// Bench: scoreboard for the scheduler. A driver task builds the expected
// entry stream from an independent per-channel toggle-time model. A
// monitor pops and compares on every write. The initial block plays a
// consumer that first stalls, then reads slowly, then reads at once.
module tog_sched_bench;

    logic        clk    = 1'b0;
    logic        rst_n  = 1'b0;
    logic [6:0]  rd_ptr = '0;
    logic        wr_en;
    logic [6:0]  wr_ptr;
    logic [31:0] wr_entry;

    always #4 clk = ~clk;

    tog_sched u_tog_sched (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_ptr   (rd_ptr),
        .wr_en    (wr_en),
        .wr_ptr   (wr_ptr),
        .wr_entry (wr_entry)
    );

    localparam int NUM_EXP = 400;
    localparam int TC0 [12] = '{119, 126, 134, 142, 150, 159, 169, 179, 189, 201, 213, 225};
    localparam bit ODD [12] = '{1, 1, 0, 0, 1, 1, 0, 0, 1, 0, 0, 1};

    int          n_chk = 0;
    int          n_bad = 0;
    int          n_wr  = 0;
    int          n_full_wr = 0;
    logic [31:0] exp_q [$];

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Driver: push expected entries computed from per-channel toggle times.
    task automatic build_expected(input int n);
        int          nt [12];
        int          k  [12];
        int          cur;
        logic [11:0] pm;
        cur = 0;
        pm  = '0;
        for (int i = 0; i < 12; i++) begin
            nt[i] = TC0[i];
            k[i]  = 0;
        end
        for (int e = 0; e < n; e++) begin
            int          nx;
            logic [11:0] m;
            nx = 32'h7fffffff;
            m  = '0;
            for (int i = 0; i < 12; i++) if (nt[i] < nx) nx = nt[i];
            for (int i = 0; i < 12; i++) begin
                if (nt[i] == nx) begin
                    m[i] = 1'b1;
                    k[i]++;
                    nt[i] += (ODD[i] && k[i] >= 2 && (k[i] % 2 == 0)) ? TC0[i] + 1 : TC0[i];
                end
            end
            exp_q.push_back({8'h00, 8'(nx - cur - 1), 4'h0, pm});
            pm  = m;
            cur = nx;
        end
    endtask

    // Monitor: compare each written entry against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            if ((wr_ptr[5:0] == rd_ptr[5:0]) && (wr_ptr[6] != rd_ptr[6])) n_full_wr++;
            check(wr_ptr == 7'(n_wr), "R8", "write pointer", wr_ptr, 7'(n_wr));
            if (exp_q.size() > 0) begin
                logic [31:0] ex;
                ex = exp_q.pop_front();
                if (n_wr == 0)
                    check(wr_entry == ex, "R1", "first entry", wr_entry, ex);
                check(wr_entry[11:0] == ex[11:0], "R4/R5/R6", "toggle mask", wr_entry[11:0], ex[11:0]);
                check(wr_entry[23:16] == ex[23:16], "R3", "delay code", wr_entry[23:16], ex[23:16]);
                check({wr_entry[31:24], wr_entry[15:12]} == 12'h0, "R2", "pad bits",
                      {wr_entry[31:24], wr_entry[15:12]}, 0);
            end
            n_wr++;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "R7", "watchdog expired", n_wr, NUM_EXP);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    // Consumer model and phase sequencing.
    initial begin
        build_expected(NUM_EXP);
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(wr_en == 1'b0, "R1", "wr_en in reset", wr_en, 0);
        check(wr_ptr == 7'd0, "R1", "wr_ptr in reset", wr_ptr, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(wr_en == 1'b0, "R1", "no write during first scan", wr_en, 0);

        // Phase 1: consumer stalled, the ring must fill and stop.
        wait (n_wr == 64);
        repeat (100) @(posedge clk);
        #1;
        check(n_wr == 64, "R7", "writes with ring full", n_wr, 64);
        check(wr_ptr == 7'd64, "R8", "pointer after fill", wr_ptr, 64);

        // Phase 2: slow consumer, one slot freed every 30 cycles.
        for (int r = 0; r < 100; r++) begin
            repeat (30) @(posedge clk);
            #1 rd_ptr = rd_ptr + 7'd1;
        end
        repeat (30) @(posedge clk);
        #1;
        check(n_wr == 164, "R7", "refill after reads", n_wr, 164);

        // Phase 3: consumer keeps up instantly.
        while (n_wr < NUM_EXP) begin
            @(posedge clk);
            #1 rd_ptr = wr_ptr;
        end
        repeat (3) @(posedge clk);
        #1;
        check(n_full_wr == 0, "R7", "writes into a full ring", n_full_wr, 0);
        check(wr_ptr == 7'(n_wr), "R8", "final pointer", wr_ptr, 7'(n_wr));
        check(exp_q.size() == 0, "R4", "entries left unmatched", exp_q.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule